// File: doc/BRIEF.md
# Pulse-Aligned Seconds and Ticks Timekeeper

This block keeps absolute time as a whole-seconds count plus a sub-second tick count that advances once per master clock cycle. When the tick count reaches its last value in a second it returns to zero and the seconds count steps up in the same cycle.

Software sets the time through a small write port. It first places the wanted seconds and ticks into pending registers, then writes a commit register. A commit with bit 0 set copies the pending time into the counters at once. A commit with bit 0 clear arms a one-shot load. The armed load is applied on the next qualifying pulse-per-second edge. A flag register picks the edge direction and which of the two pulse inputs counts. Each pulse input passes through a two-flop synchronizer before edge detection. A one-cycle interrupt pulse marks every qualifying edge.

Time is read as two 32-bit words. Reading seconds also freezes the tick count of that same cycle, so a later read of ticks returns a matching pair.

Top module: `pps_timekeeper`

## Requirements
- R1: After reset, seconds, ticks and the tick snapshot are zero, `pps_irq` is low, the flags select falling edges on `pps_src[0]`, and no load is armed.
- R2: Ticks advance by one each cycle. A tick value of `TICKS_PER_SEC-1` or above is followed by ticks 0, and seconds rise by one in that same cycle.
- R3: Writes to address 0 (pending seconds) and address 1 (pending ticks) leave the running time unchanged.
- R4: A write to address 3 with bit 0 set makes the counters show the pending seconds and ticks in the next cycle. Counting then resumes from those values.
- R5: A write to address 3 with bit 0 clear arms a load. The counters take the pending values, and `pps_irq` is high, in the cycle after the third rising clock edge that follows the qualifying change on the selected pulse input.
- R6: An armed load is used once. A later qualifying edge raises `pps_irq` but leaves the time counting on.
- R7: Flag bit 0 (address 2) selects the edge: 0 selects falling, 1 selects rising. An edge of the other direction causes neither a load nor an interrupt.
- R8: Flag bit 1 selects the source: 0 selects `pps_src[0]`, 1 selects `pps_src[1]`. Edges on the unselected input are ignored.
- R9: `pps_irq` is a one-cycle pulse on every qualifying edge, whether or not a load is armed.
- R10: With `rd_sel` at 0, `rd_data` shows the live seconds. A clock edge with `rd_en` high and `rd_sel` at 0 stores that cycle's ticks. With `rd_sel` at 1, `rd_data` shows the stored ticks until the next seconds read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | 0 pending seconds, 1 pending ticks, 2 flags, 3 commit |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; with `rd_sel` 0 it captures the tick snapshot |
| rd_sel | input | 1 | 0 live seconds, 1 tick snapshot |
| rd_data | output | 32 | Readback word, combinational from state |
| pps_src | input | 2 | Two asynchronous pulse-per-second inputs |
| pps_irq | output | 1 | One-cycle pulse on each qualifying edge |

## Verification
An immediate commit is due in the cycle after the clock edge that takes the write. A pulse-driven load and its interrupt are due only after the third clock edge past the input change. This allows one edge for each synchronizer stage and one for the registered detection. The bench changes inputs on falling clock edges and keeps a cycle-accurate model of seconds and ticks, advancing it by one per falling edge. For a pulse it samples the interrupt after each of the three following edges and expects it low, low, then high. The tick snapshot is checked several cycles after the seconds read, to show that it holds its captured value.

// File: rtl/tk_pkg.sv
package tk_pkg;
    parameter int TK_SEC_W  = 32;
    parameter int TK_TICK_W = 32;
    parameter int TK_DATA_W = 32;
    parameter int TK_ADDR_W = 2;
    parameter int TK_NUM_SRC = 2;

    // flag bit positions
    parameter int TK_FLAG_RISE = 0;
    parameter int TK_FLAG_SRC  = 1;
    parameter int TK_FLAG_W    = 2;

    typedef enum logic [TK_ADDR_W-1:0] {
        TK_A_SECS   = 2'd0,
        TK_A_TICKS  = 2'd1,
        TK_A_FLAGS  = 2'd2,
        TK_A_COMMIT = 2'd3
    } tk_addr_e;

    typedef struct packed {
        logic [TK_SEC_W-1:0]  secs;
        logic [TK_TICK_W-1:0] ticks;
    } tk_time_t;
endpackage

// File: rtl/tk_pps_front.sv
module tk_pps_front #(
    parameter int NUM_SRC = tk_pkg::TK_NUM_SRC,
    localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pps_in,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic               rise_sel,
    output logic               edge_o
);
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] fall;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        // [0] first sync stage, [1] second sync stage, [2] previous synced value
        logic [2:0] sh_d, sh_q;

        always_comb begin
            sh_d = {sh_q[1:0], pps_in[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end

        assign rise[g] =  sh_q[1] & ~sh_q[2];
        assign fall[g] = ~sh_q[1] &  sh_q[2];
    end

    always_comb begin
        edge_o = rise_sel ? rise[src_sel] : fall[src_sel];
    end
endmodule

// File: rtl/tk_time_core.sv
module tk_time_core
    import tk_pkg::*;
#(
    parameter int TICKS_PER_SEC = 100_000_000
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_en,
    input  tk_time_t load_val,
    output tk_time_t now
);
    localparam logic [TK_TICK_W-1:0] LAST_TICK = TK_TICK_W'(TICKS_PER_SEC - 1);

    tk_time_t time_d, time_q;

    always_comb begin
        time_d = time_q;
        if (load_en) begin
            time_d = load_val;
        end else if (time_q.ticks >= LAST_TICK) begin
            time_d.ticks = '0;
            time_d.secs  = time_q.secs + 1'b1;
        end else begin
            time_d.ticks = time_q.ticks + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) time_q <= '0;
        else        time_q <= time_d;
    end

    assign now = time_q;
endmodule

// File: rtl/tk_readback.sv
module tk_readback
    import tk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic                 rd_sel,
    input  tk_time_t             now,
    output logic [TK_DATA_W-1:0] rd_data
);
    logic [TK_TICK_W-1:0] snap_d, snap_q;

    always_comb begin
        snap_d = snap_q;
        if (rd_en && !rd_sel) snap_d = now.ticks;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

    always_comb begin
        rd_data = rd_sel ? TK_DATA_W'(snap_q) : TK_DATA_W'(now.secs);
    end
endmodule

// File: rtl/pps_timekeeper.sv
module pps_timekeeper
    import tk_pkg::*;
#(
    parameter int TICKS_PER_SEC = 100_000_000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [TK_ADDR_W-1:0]  wr_addr,
    input  logic [TK_DATA_W-1:0]  wr_data,
    input  logic                  rd_en,
    input  logic                  rd_sel,
    output logic [TK_DATA_W-1:0]  rd_data,
    input  logic [TK_NUM_SRC-1:0] pps_src,
    output logic                  pps_irq
);
    typedef struct packed {
        tk_time_t               pend;
        logic [TK_FLAG_W-1:0]   flags;
        logic                   armed;
        logic                   irq;
    } ctl_t;

    ctl_t     ctl_d, ctl_q;
    logic     pps_edge;
    logic     load_en;
    logic     imm_wr;
    logic     armed_now;
    tk_time_t load_val;
    tk_time_t time_now;

    tk_pps_front #(.NUM_SRC(TK_NUM_SRC)) i_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .pps_in   (pps_src),
        .src_sel  (ctl_q.flags[TK_FLAG_SRC]),
        .rise_sel (ctl_q.flags[TK_FLAG_RISE]),
        .edge_o   (pps_edge)
    );

    always_comb begin
        ctl_d    = ctl_q;
        load_en  = 1'b0;
        load_val = ctl_q.pend;
        imm_wr   = wr_en && (wr_addr == TK_A_COMMIT);

        ctl_d.irq = pps_edge;
        if (ctl_q.armed && pps_edge) begin
            load_en     = 1'b1;
            ctl_d.armed = 1'b0;
        end

        if (wr_en) begin
            unique case (tk_addr_e'(wr_addr))
                TK_A_SECS:   ctl_d.pend.secs  = wr_data[TK_SEC_W-1:0];
                TK_A_TICKS:  ctl_d.pend.ticks = wr_data[TK_TICK_W-1:0];
                TK_A_FLAGS:  ctl_d.flags      = wr_data[TK_FLAG_W-1:0];
                TK_A_COMMIT: begin
                    if (wr_data[0]) begin
                        load_en     = 1'b1;
                        ctl_d.armed = 1'b0;
                    end else begin
                        ctl_d.armed = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    tk_time_core #(.TICKS_PER_SEC(TICKS_PER_SEC)) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .load_val (load_val),
        .now      (time_now)
    );

    tk_readback i_rb (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_sel  (rd_sel),
        .now     (time_now),
        .rd_data (rd_data)
    );

    assign armed_now = ctl_q.armed;
    assign pps_irq   = ctl_q.irq;
endmodule

// File: rtl/tk_checker.sv
module tk_checker
    import tk_pkg::*;
#(
    parameter int TICKS_PER_SEC = 100_000_000
) (
    input logic     clk,
    input logic     rst_n,
    input logic     pps_irq,
    input logic     pps_edge,
    input logic     armed,
    input logic     imm_wr,
    input logic     load_en,
    input tk_time_t load_val,
    input tk_time_t time_now
);
    localparam logic [TK_TICK_W-1:0] LAST_TICK = TK_TICK_W'(TICKS_PER_SEC - 1);

    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && time_now.ticks < LAST_TICK) |=>
            (time_now.ticks == $past(time_now.ticks) + 1'b1) && $stable(time_now.secs));

    // R2
    tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && time_now.ticks >= LAST_TICK) |=>
            (time_now.ticks == '0) && (time_now.secs == $past(time_now.secs) + 1'b1));

    // R4
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (time_now == $past(load_val)));

    // R6
    arm_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && pps_edge && !imm_wr) |=> (pps_irq && !armed));

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pps_irq |=> !pps_irq);
endmodule

bind pps_timekeeper tk_checker #(.TICKS_PER_SEC(TICKS_PER_SEC)) i_tk_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .pps_irq  (pps_irq),
    .pps_edge (pps_edge),
    .armed    (armed_now),
    .imm_wr   (imm_wr),
    .load_en  (load_en),
    .load_val (load_val),
    .time_now (time_now)
);

// File: tb/test_pps_timekeeper.sv
module test_pps_timekeeper;
    localparam int TPS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic [1:0]  pps_src = '0;
    logic        pps_irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_s = '0;
    logic [31:0] m_t = '0;

    always #10 clk = ~clk;

    pps_timekeeper #(.TICKS_PER_SEC(TPS)) i_pps_timekeeper (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .pps_src(pps_src), .pps_irq(pps_irq)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // model advance by one cycle (R2)
    task automatic step();
        @(negedge clk);
        if (m_t >= TPS - 1) begin
            m_t = '0;
            m_s = m_s + 1;
        end else begin
            m_t = m_t + 1;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic check_time(input string req);
        logic [31:0] es, et, gs, gt;
        es = m_s; et = m_t;
        rd_sel = 1'b0; rd_en = 1'b1;
        #1 gs = rd_data;
        step();
        rd_en = 1'b0; rd_sel = 1'b1;
        #1 gt = rd_data;
        rd_sel = 1'b0;
        chk(gs == es, {req, " seconds"}, gs, es);
        chk(gt == et, {req, " ticks"}, gt, et);
    endtask

    // drive one pulse input level, follow three edges, check irq and load
    task automatic pulse(input int src, input logic lvl, input logic fire,
                         input logic load, input logic [31:0] s, input logic [31:0] t, input string req);
        pps_src[src] = lvl;
        step(); #1 chk(pps_irq == 1'b0, {req, " irq stage1"}, pps_irq, 0);
        step(); #1 chk(pps_irq == 1'b0, {req, " irq stage2"}, pps_irq, 0);
        step(); #1 chk(pps_irq == fire, {req, " irq due"}, pps_irq, fire);
        if (load) begin
            m_s = s; m_t = t;
        end
        check_time({req, " time after edge"});
        #1 chk(pps_irq == 1'b0, "R9 irq one cycle", pps_irq, 0);
    endtask

    task automatic t_reset();
        #1;
        rd_sel = 1'b0; #1 chk(rd_data == 0, "R1 reset seconds", rd_data, 0);
        rd_sel = 1'b1; #1 chk(rd_data == 0, "R1 reset snapshot", rd_data, 0);
        rd_sel = 1'b0;
        chk(pps_irq == 1'b0, "R1 reset irq", pps_irq, 0);
    endtask

    task automatic t_count();
        check_time("R2 counting from reset");
        repeat (20) step();
        check_time("R2 across a second boundary");
        wr(0, 32'd2); wr(1, 32'd20); wr(3, 32'd1);
        m_s = 32'd2; m_t = 32'd20;
        check_time("R2 out-of-range ticks wrap");
        check_time("R2 after wrap");
    endtask

    task automatic t_imm();
        wr(0, 32'd7); wr(1, 32'd5); wr(3, 32'd1);
        m_s = 32'd7; m_t = 32'd5;
        check_time("R4 immediate load");
        repeat (9) step();
        check_time("R4 counting resumes");
    endtask

    task automatic t_pending();
        wr(0, 32'd99); wr(1, 32'd9);
        repeat (3) step();
        check_time("R3 pending writes ignored");
    endtask

    task automatic t_arm();
        wr(0, 32'd40); wr(1, 32'd2); wr(2, 32'd0); wr(3, 32'd0);
        pulse(0, 1'b1, 1'b0, 1'b0, 0, 0, "R7 rising ignored in falling mode");
        pulse(0, 1'b0, 1'b1, 1'b1, 32'd40, 32'd2, "R5 falling edge load");
    endtask

    task automatic t_once();
        pulse(0, 1'b1, 1'b0, 1'b0, 0, 0, "R6 rise no fire");
        pulse(0, 1'b0, 1'b1, 1'b0, 0, 0, "R6 second edge no reload");
    endtask

    task automatic t_source();
        wr(2, 32'd3); wr(0, 32'd60); wr(1, 32'd1); wr(3, 32'd0);
        pulse(0, 1'b1, 1'b0, 1'b0, 0, 0, "R8 unselected rise ignored");
        pulse(0, 1'b0, 1'b0, 1'b0, 0, 0, "R8 unselected fall ignored");
        pulse(1, 1'b1, 1'b1, 1'b1, 32'd60, 32'd1, "R8 selected rising load");
    endtask

    task automatic t_readback();
        logic [31:0] et;
        rd_sel = 1'b0; rd_en = 1'b1;
        et = m_t;
        step();
        rd_en = 1'b0;
        repeat (5) step();
        rd_sel = 1'b1;
        #1 chk(rd_data == et, "R10 snapshot holds", rd_data, et);
        rd_sel = 1'b0;
        #1 chk(rd_data == m_s, "R10 live seconds", rd_data, m_s);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        m_s = '0; m_t = '0;
        t_count();
        t_imm();
        t_pending();
        t_arm();
        t_once();
        t_source();
        t_readback();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule